// File: doc/BRIEF.md
# Read/Write Pointer Override Controller

This block holds the read and write address counters of a frame buffer. Each counter steps forward by one whenever its enable is high. It wraps to zero after the last address of the configured depth. Six active-low control pins can take a counter over instead: clear-read, set-read, select-read, clear-write, set-write and select-write. A clear forces the pointer to zero. A set loads the pointer from that pointer's load-address input. A select reloads the pointer from a shared mark register.

Each pin is brought into the clock domain through two flops, and a third flop keeps the previous sample. A 6-bit mode field chooses, pin by pin, how the pin acts. In pulse mode a falling edge overrides the counter for exactly one cycle. In level mode the pin overrides the counter for as long as it is held low. A catch bit makes every write-pointer set also copy the loaded value into the mark register. The read and write pointers can then be sent back to a remembered write position.

Top module: `ptr_override_ctrl`

## Requirements
- R1: After reset, the read pointer, the write pointer and the mark register are all zero.
- R2: With no override active and its enable high, a pointer increments by one per clock and goes from DEPTH-1 back to 0. With its enable low and no override active, it holds its value.
- R3: An active clear override forces its pointer to zero.
- R4: An active set override loads its pointer from that pointer's load-address input.
- R5: An active select override loads its pointer from the mark register.
- R6: When several overrides on one pointer are active in the same cycle, clear wins over set, and set wins over select.
- R7: In pulse mode (mode bit 0), a pin first sampled low at rising edge k overrides its pointer at edge k+2 only. Counting resumes at edge k+3 even while the pin stays low.
- R8: In level mode (mode bit 1), the override is applied at every edge from k+2 while the pin stays low. If the pin is first sampled high again at edge m, the override still applies at edges m and m+1, and counting resumes at edge m+2.
- R9: With the catch bit at 1, a write set that takes effect also writes the loaded value into the mark register. With the catch bit at 0, the mark register never changes.
- R10: The mode field bits map to the pins as follows: bit 5 set-read, bit 4 clear-read, bit 3 select-write, bit 2 select-read, bit 1 set-write, bit 0 clear-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeCfg | input | 6 | Per-pin mode, 1 = level, 0 = pulse (mapping in R10) |
| catchCfg | input | 1 | 1 = write set also loads the mark register |
| rdSetN | input | 1 | Set read pointer, active low |
| rdClrN | input | 1 | Clear read pointer, active low |
| rdSelN | input | 1 | Reload read pointer from mark, active low |
| wrSetN | input | 1 | Set write pointer, active low |
| wrClrN | input | 1 | Clear write pointer, active low |
| wrSelN | input | 1 | Reload write pointer from mark, active low |
| rdEn | input | 1 | Read pointer increment enable |
| wrEn | input | 1 | Write pointer increment enable |
| rdLoadAddr | input | ADDR_W | Value loaded by a read set |
| wrLoadAddr | input | ADDR_W | Value loaded by a write set |
| rdPtr | output | ADDR_W | Read address counter |
| wrPtr | output | ADDR_W | Write address counter |
| markAddr | output | ADDR_W | Mark register |

## Verification
Several overrides can fall on the same pointer in the same cycle, and increment can also collide with an override. To provoke the first case, the bench holds clear, set and select of the write pointer low together in level mode with the catch bit off. It then releases them one at a time, and after each release it checks that the pointer shows the next winner in priority order and that the mark register has not moved. The increment collision is judged by holding the enable high across a pulse: the pointer must show the override value at exactly the third edge and count up again from it on the next one.

// File: rtl/ptr_ovr_pkg.sv
package ptr_ovr_pkg;

  localparam int PIN_CNT = 6;

  // Pin positions; these match the mode-field bit positions.
  localparam int PIN_WR_CLR = 0;
  localparam int PIN_WR_SET = 1;
  localparam int PIN_RD_SEL = 2;
  localparam int PIN_WR_SEL = 3;
  localparam int PIN_RD_CLR = 4;
  localparam int PIN_RD_SET = 5;

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic rdClr;
    logic rdSet;
    logic rdSel;
    logic wrClr;
    logic wrSet;
    logic wrSel;
    logic wrCatch;
  } ovr_t;

endpackage

// File: rtl/pin_conditioner.sv
module pin_conditioner (
  input  logic clk,
  input  logic rstN,
  input  logic pinN,
  input  logic levelMode,
  output logic active
);
  logic syncA, syncB, prevB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
      prevB <= 1'b1;
    end else begin
      syncA <= pinN;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  // Level mode: active while the synced pin is low. Pulse mode: active for one cycle on a high-to-low change.
  assign active = levelMode ? ~syncB : (prevB & ~syncB);
endmodule

// File: rtl/ptr_ovr_ctrl.sv
module ptr_ovr_ctrl
  import ptr_ovr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_CNT-1:0] pinsN,
  input  logic [PIN_CNT-1:0] modeCfg,
  input  logic               catchCfg,
  output ovr_t               ovr
);
  logic [PIN_CNT-1:0] act;

  for (genvar i = 0; i < PIN_CNT; i++) begin : gPin
    pin_conditioner uCond (
      .clk      (clk),
      .rstN     (rstN),
      .pinN     (pinsN[i]),
      .levelMode(modeCfg[i]),
      .active   (act[i])
    );
  end

  always_comb begin
    ovr.rdClr   = act[PIN_RD_CLR];
    ovr.rdSet   = act[PIN_RD_SET];
    ovr.rdSel   = act[PIN_RD_SEL];
    ovr.wrClr   = act[PIN_WR_CLR];
    ovr.wrSet   = act[PIN_WR_SET];
    ovr.wrSel   = act[PIN_WR_SEL];
    // The mark is captured only when the write set actually wins over clear.
    ovr.wrCatch = catchCfg & act[PIN_WR_SET] & ~act[PIN_WR_CLR];
  end
endmodule

// File: rtl/addr_counter.sv
module addr_counter #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              set,
  input  logic              sel,
  input  logic              en,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [ADDR_W-1:0] markAddr,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ptr <= '0;
    else if (clr)  ptr <= '0;
    else if (set)  ptr <= loadAddr;
    else if (sel)  ptr <= markAddr;
    else if (en)   ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/ptr_ovr_dpath.sv
module ptr_ovr_dpath
  import ptr_ovr_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ovr_t              ovr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] rdLoadAddr,
  input  logic [ADDR_W-1:0] wrLoadAddr,
  output logic [ADDR_W-1:0] rdPtr,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] markAddr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            markAddr <= '0;
    else if (ovr.wrCatch) markAddr <= wrLoadAddr;
  end

  addr_counter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uRdCnt (
    .clk(clk), .rstN(rstN),
    .clr(ovr.rdClr), .set(ovr.rdSet), .sel(ovr.rdSel), .en(rdEn),
    .loadAddr(rdLoadAddr), .markAddr(markAddr), .ptr(rdPtr)
  );

  addr_counter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uWrCnt (
    .clk(clk), .rstN(rstN),
    .clr(ovr.wrClr), .set(ovr.wrSet), .sel(ovr.wrSel), .en(wrEn),
    .loadAddr(wrLoadAddr), .markAddr(markAddr), .ptr(wrPtr)
  );
endmodule

// File: rtl/ptr_override_ctrl.sv
module ptr_override_ctrl
  import ptr_ovr_pkg::*;
#(
  parameter  int DEPTH  = 1024,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        modeCfg,
  input  logic              catchCfg,
  input  logic              rdSetN,
  input  logic              rdClrN,
  input  logic              rdSelN,
  input  logic              wrSetN,
  input  logic              wrClrN,
  input  logic              wrSelN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] rdLoadAddr,
  input  logic [ADDR_W-1:0] wrLoadAddr,
  output logic [ADDR_W-1:0] rdPtr,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] markAddr
);
  ovr_t               ovr;
  logic [PIN_CNT-1:0] pinsN;

  assign pinsN = {rdSetN, rdClrN, wrSelN, rdSelN, wrSetN, wrClrN};

  ptr_ovr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .pinsN(pinsN),
    .modeCfg(modeCfg), .catchCfg(catchCfg), .ovr(ovr)
  );

  ptr_ovr_dpath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uDpath (
    .clk(clk), .rstN(rstN), .ovr(ovr),
    .rdEn(rdEn), .wrEn(wrEn),
    .rdLoadAddr(rdLoadAddr), .wrLoadAddr(wrLoadAddr),
    .rdPtr(rdPtr), .wrPtr(wrPtr), .markAddr(markAddr)
  );
endmodule

// File: rtl/ptr_ovr_checker.sv
module ptr_ovr_checker
  import ptr_ovr_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [5:0]        modeCfg,
  input logic              catchCfg,
  input logic              rdEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrLoadAddr,
  input logic [ADDR_W-1:0] rdPtr,
  input logic [ADDR_W-1:0] wrPtr,
  input logic [ADDR_W-1:0] markAddr,
  input ovr_t              ovr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  logic wrAny, rdAny;
  assign wrAny = ovr.wrClr | ovr.wrSet | ovr.wrSel;
  assign rdAny = ovr.rdClr | ovr.rdSet | ovr.rdSel;

  a_r3_wr_clr: assert property (@(posedge clk) disable iff (!rstN)
    ovr.wrClr |=> wrPtr == '0);
  a_r3_rd_clr: assert property (@(posedge clk) disable iff (!rstN)
    ovr.rdClr |=> rdPtr == '0);
  a_r4_wr_set: assert property (@(posedge clk) disable iff (!rstN)
    (ovr.wrSet && !ovr.wrClr) |=> wrPtr == $past(wrLoadAddr));
  a_r5_rd_sel: assert property (@(posedge clk) disable iff (!rstN)
    (ovr.rdSel && !ovr.rdSet && !ovr.rdClr) |=> rdPtr == $past(markAddr));
  a_r2_wr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAny && wrPtr == LAST) |=> wrPtr == '0);
  a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn && !rdAny) |=> $stable(rdPtr));
  a_r9_no_catch: assert property (@(posedge clk) disable iff (!rstN)
    !catchCfg |=> $stable(markAddr));
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (!modeCfg[4] && ovr.rdClr) |=> (modeCfg[4] || !ovr.rdClr));
endmodule

bind ptr_override_ctrl ptr_ovr_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .modeCfg(modeCfg), .catchCfg(catchCfg),
  .rdEn(rdEn), .wrEn(wrEn), .wrLoadAddr(wrLoadAddr),
  .rdPtr(rdPtr), .wrPtr(wrPtr), .markAddr(markAddr), .ovr(ovr)
);

// File: tb/tb_ptr_override_ctrl.sv
`timescale 1ns/1ps
module tb_ptr_override_ctrl;
  localparam int DEPTH = 12;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] modeCfg = '0;
  logic catchCfg = 1'b0;
  logic [5:0] pinsN = 6'h3F;  // {rdSet, rdClr, wrSel, rdSel, wrSet, wrClr}
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic [AW-1:0] rdPtr, wrPtr, markAddr;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  ptr_override_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .modeCfg(modeCfg), .catchCfg(catchCfg),
    .rdSetN(pinsN[5]), .rdClrN(pinsN[4]), .rdSelN(pinsN[2]),
    .wrSetN(pinsN[1]), .wrClrN(pinsN[0]), .wrSelN(pinsN[3]),
    .rdEn(rdEn), .wrEn(wrEn), .rdLoadAddr(loadAddr), .wrLoadAddr(loadAddr),
    .rdPtr(rdPtr), .wrPtr(wrPtr), .markAddr(markAddr)
  );

  // Each entry: {pin index, load value, expected read, write, mark}, one hex digit per field
  localparam logic [19:0] VEC [8] = '{
    20'h17077, 20'h20777, 20'h00707, 20'h40007,
    20'h55507, 20'h30577, 20'h13533, 20'h20333
  };

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick(3);
    check("R1", "rdPtr", rdPtr, 0);
    check("R1", "wrPtr", wrPtr, 0);
    check("R1", "mark", markAddr, 0);
    rstN = 1'b1;
    tick(2);

    // Table walk in pulse mode with catch on: R3 R4 R5 R9 R7
    catchCfg = 1'b1;
    for (int i = 0; i < 8; i++) begin
      loadAddr = VEC[i][15:12];
      pinsN[VEC[i][19:16]] = 1'b0;
      tick(3);
      check("R7", "rdPtr", rdPtr, VEC[i][11:8]);
      check("R4", "wrPtr", wrPtr, VEC[i][7:4]);
      check("R9", "mark", markAddr, VEC[i][3:0]);
      pinsN = 6'h3F;
      tick(3);
      check("R5", "rdPtr after release", rdPtr, VEC[i][11:8]);
    end

    // R2: count 10 steps from 3 with wrap at DEPTH-1, then hold
    wrEn = 1'b1; tick(10);
    check("R2", "wrPtr wrap", wrPtr, 1);
    wrEn = 1'b0; tick(2);
    check("R2", "wrPtr hold", wrPtr, 1);

    // R7: pulse clear on read with enable high, pin held low
    rdEn = 1'b1; pinsN[4] = 1'b0; tick(3);
    check("R7", "rdPtr at k+2", rdPtr, 0);
    tick(2);
    check("R7", "rdPtr resumes", rdPtr, 2);
    pinsN = 6'h3F; rdEn = 1'b0; tick(3);

    // R8: level clear on read (mode bit 4)
    modeCfg = 6'b010000; rdEn = 1'b1; pinsN[4] = 1'b0; tick(3);
    check("R8", "rdPtr cleared", rdPtr, 0);
    tick(3);
    check("R8", "rdPtr held", rdPtr, 0);
    pinsN[4] = 1'b1; tick(3);
    check("R8", "rdPtr after release", rdPtr, 1);
    rdEn = 1'b0; tick(1);

    // R6: priority with write clear/set/select in level mode, catch off
    modeCfg = 6'b001011; catchCfg = 1'b0; loadAddr = 4'd9;
    pinsN[0] = 1'b0; pinsN[1] = 1'b0; pinsN[3] = 1'b0; tick(3);
    check("R6", "clear wins", wrPtr, 0);
    check("R9", "mark kept", markAddr, 3);
    pinsN[0] = 1'b1; tick(3);
    check("R6", "set wins over select", wrPtr, 9);
    check("R9", "no catch", markAddr, 3);
    pinsN[1] = 1'b1; tick(3);
    check("R6", "select alone", wrPtr, 3);
    pinsN = 6'h3F; tick(3);

    // R10: only bit 1 (write set) is level; read set stays pulse
    modeCfg = 6'b000010; loadAddr = 4'd6; rdEn = 1'b1; wrEn = 1'b1;
    pinsN[5] = 1'b0; pinsN[1] = 1'b0; tick(6);
    check("R10", "rdPtr pulse", rdPtr, 9);
    check("R10", "wrPtr level", wrPtr, 6);
    pinsN = 6'h3F; rdEn = 1'b0; wrEn = 1'b0; tick(3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule